// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block is the receive half of an asynchronous serial port. It watches a line that rests high. When the line falls, it checks the low level again at the middle of the bit so that a short glitch does not start a frame. It then samples eight data bits, least significant first. If parity is enabled, a parity bit follows. Last comes a single stop bit. The completed character is placed in a holding register that the host reads.

A small status block reports four conditions: data ready, overrun, parity error and framing error. Each condition has its own rule for whether the new character reaches the holding register. Any error flag that is set stops the receiver from accepting new frames until the host clears that flag. Bit timing comes from an external tick that pulses sixteen times per bit. One enable gates two level interrupt requests: one for received data and one for errors.

Top module: `async_rx_unit`

## Requirements
- R1: After reset, `rx_data` is 0, and `data_ready`, `ovr_err`, `par_err`, `frm_err`, `irq_rx` and `irq_err` are all 0.
- R2: Each bit lasts 16 `os_tick` pulses. A low level on the idle line, seen again on the 8th following tick, confirms a start bit. Data bits are then taken at their midpoints, first bit into `rx_data[0]`. A clean frame loads `rx_data` and sets `data_ready`.
- R3: If the line is high again when the start bit is re-checked, the event is dropped and no flag changes.
- R4: With `par_en`=1, a parity bit follows D7. Its expected value is the XOR of the data bits when `par_odd`=0, and the inverse of that XOR when `par_odd`=1. A mismatch sets `par_err` and loads the data into `rx_data`, and `data_ready` keeps its previous value.
- R5: With `par_en`=0, the stop bit follows D7 directly and `par_err` is never set.
- R6: A stop bit sampled low sets `frm_err` and loads the data into `rx_data`, and `data_ready` keeps its previous value.
- R7: A frame that completes while `data_ready` is 1 sets `ovr_err`. `rx_data` is left unchanged and `data_ready` stays 1.
- R8: While any of `ovr_err`, `par_err` or `frm_err` is 1, start bits are ignored: no frame is received and `rx_data` does not change.
- R9: A `rd_strobe` pulse clears `data_ready`. A `stat_wr` pulse clears each error flag whose bit in `stat_wdata` is 0 and leaves a flag unchanged where the bit is 1. The bit positions are: bit0 overrun, bit1 parity, bit2 framing. A flag being set in the same cycle wins over a clear.
- R10: `irq_rx` equals `data_ready` AND `int_en`. `irq_err` equals (`ovr_err` OR `par_err` OR `frm_err`) AND `int_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Parity bit expected |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| int_en | input | 1 | Interrupt enable |
| rd_strobe | input | 1 | Host read of data, clears data ready |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 3 | Write-0-to-clear mask {framing, parity, overrun} |
| rx_data | output | 8 | Received character |
| data_ready | output | 1 | Unread character present |
| ovr_err | output | 1 | Overrun flag |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| irq_rx | output | 1 | Receive-data interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
A bit counter that slips sampling points off center shows up within one frame. It appears as a shifted or wrong character, or as a false parity or framing flag, when the event for that frame reaches the ports. A status path that loads data on overrun, or sets data ready on an error, changes `rx_data` or `data_ready` in the cycle after the stop bit is sampled. A receiver that does not hold off while a flag is set produces an unexpected event, or a changed `rx_data`, one frame time after the blocked start bit.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  // bit2 framing, bit1 parity, bit0 overrun
  typedef struct packed {
    logic frm;
    logic par;
    logic ovr;
  } err_flags_t;
endpackage

// File: rtl/async_rx_framer.sv
module async_rx_framer
  import async_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 hold,
  output logic                 busy,
  output logic                 frame_done,
  output logic [DATA_BITS-1:0] frame_data,
  output logic                 par_bad,
  output logic                 stop_bad
);
  localparam int CW = $clog2(OSR);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

  function automatic logic want_parity(input logic [DATA_BITS-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  rx_state_e            state;
  logic [1:0]           sync_q;
  logic                 rxd_s;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bidx;
  logic [DATA_BITS-1:0] shreg;
  logic                 cfg_par, cfg_odd, par_bad_q;
  logic                 mid_hit, bit_hit;

  assign rxd_s      = sync_q[1];
  assign busy       = (state != RX_IDLE);
  assign frame_data = shreg;
  assign par_bad    = par_bad_q;
  assign mid_hit    = tick && (cnt == MID_CNT);
  assign bit_hit    = tick && (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 2'b11;
      state      <= RX_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      shreg      <= '0;
      cfg_par    <= 1'b0;
      cfg_odd    <= 1'b0;
      par_bad_q  <= 1'b0;
      stop_bad   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      sync_q     <= {sync_q[0], rxd};
      frame_done <= 1'b0;
      if (tick) begin
        cnt <= (state == RX_IDLE || cnt == LAST_CNT) ? '0 : cnt + 1'b1;
        unique case (state)
          RX_IDLE: if (!hold && !rxd_s) begin
            state     <= RX_START;
            cfg_par   <= par_en;
            cfg_odd   <= par_odd;
            par_bad_q <= 1'b0;
          end
          RX_START: if (cnt == MID_CNT) begin
            cnt  <= '0;
            bidx <= '0;
            state <= rxd_s ? RX_IDLE : RX_DATA;
          end
          RX_DATA: if (cnt == LAST_CNT) begin
            shreg <= {rxd_s, shreg[DATA_BITS-1:1]};
            if (bidx == LAST_BIT) state <= cfg_par ? RX_PAR : RX_STOP;
            else                  bidx  <= bidx + 1'b1;
          end
          RX_PAR: if (cnt == LAST_CNT) begin
            par_bad_q <= (rxd_s != want_parity(shreg, cfg_odd));
            state     <= RX_STOP;
          end
          RX_STOP: if (cnt == LAST_CNT) begin
            stop_bad   <= !rxd_s;
            frame_done <= 1'b1;
            state      <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R3: a start that is high again at the re-check returns to idle
  p_noise_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && mid_hit && rxd_s) |=> (state == RX_IDLE));

  // R2: a completed frame is only reported from the stop bit
  p_done_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(state) == RX_STOP && $past(bit_hit)));

  // R5: without parity the data phase leads straight to the stop bit
  p_no_par_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_PAR) |-> cfg_par);
endmodule

// File: rtl/async_rx_status.sv
module async_rx_status
  import async_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_done,
  input  logic [DATA_BITS-1:0] frame_data,
  input  logic                 par_bad,
  input  logic                 stop_bad,
  input  logic                 rd_strobe,
  input  logic                 stat_wr,
  input  err_flags_t           stat_wdata,
  input  logic                 int_en,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rdy,
  output err_flags_t           err,
  output logic                 any_err,
  output logic                 irq_rx,
  output logic                 irq_err
);
  function automatic err_flags_t next_err(input err_flags_t cur, input logic wr,
                                          input err_flags_t mask, input logic done,
                                          input logic full, input logic pb, input logic sb);
    err_flags_t n;
    n = wr ? (cur & mask) : cur;
    if (done) begin
      if (full) n.ovr = 1'b1;
      else begin
        n.par = n.par | pb;
        n.frm = n.frm | sb;
      end
    end
    return n;
  endfunction

  logic frame_bad, load_ok;
  assign frame_bad = par_bad || stop_bad;
  assign load_ok   = frame_done && !rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rdy     <= 1'b0;
      err     <= '0;
    end else begin
      err <= next_err(err, stat_wr, stat_wdata, frame_done, rdy, par_bad, stop_bad);
      if (load_ok) rx_data <= frame_data;
      if (load_ok && !frame_bad) rdy <= 1'b1;
      else if (rd_strobe)        rdy <= 1'b0;
    end
  end

  assign any_err = err.ovr | err.par | err.frm;
  assign irq_rx  = rdy & int_en;
  assign irq_err = any_err & int_en;

  // R7: overrun keeps the held character and sets the flag
  p_ovr_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rdy) |=> ($stable(rx_data) && err.ovr && rdy));

  // R4 R6: an erroneous frame leaves data ready clear
  p_err_no_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !rdy && frame_bad) |=> !rdy);

  // R2: data ready rises only on a completed frame
  p_ready_from_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(frame_done));
endmodule

// File: rtl/async_rx_unit.sv
module async_rx_unit
  import async_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 rxd,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 int_en,
  input  logic                 rd_strobe,
  input  logic                 stat_wr,
  input  logic [2:0]           stat_wdata,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 data_ready,
  output logic                 ovr_err,
  output logic                 par_err,
  output logic                 frm_err,
  output logic                 irq_rx,
  output logic                 irq_err
);
  logic                 busy, frame_done, par_bad, stop_bad, any_err;
  logic [DATA_BITS-1:0] frame_data;
  err_flags_t           err;

  async_rx_framer #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .hold(any_err),
    .busy(busy), .frame_done(frame_done), .frame_data(frame_data),
    .par_bad(par_bad), .stop_bad(stop_bad)
  );

  async_rx_status #(.DATA_BITS(DATA_BITS)) u_status (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
    .par_bad(par_bad), .stop_bad(stop_bad), .rd_strobe(rd_strobe),
    .stat_wr(stat_wr), .stat_wdata(err_flags_t'(stat_wdata)), .int_en(int_en),
    .rx_data(rx_data), .rdy(data_ready), .err(err), .any_err(any_err),
    .irq_rx(irq_rx), .irq_err(irq_err)
  );

  assign ovr_err = err.ovr;
  assign par_err = err.par;
  assign frm_err = err.frm;

  // R8: with a flag set, an idle receiver stays idle
  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err && !busy) |=> !busy);

  // R5: parity error flag only rises on a frame that carried a parity bit
  p_par_needs_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> $past(frame_done && par_bad));
endmodule

// File: tb/async_rx_unit_bench.sv
module async_rx_unit_bench;
  localparam int BIT_CLK = 32; // 16 ticks, one tick every 2 clocks

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, int_en = 1'b0;
  logic rd_strobe = 1'b0, stat_wr = 1'b0;
  logic [2:0] stat_wdata = 3'b111;
  logic [7:0] rx_data;
  logic data_ready, ovr_err, par_err, frm_err, irq_rx, irq_err;

  int checks = 0, fails = 0, events = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] d;
    logic rdy, ovr, pe, fe;
    string req;
  } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;
  always @(posedge clk) os_tick <= rst_n ? ~os_tick : 1'b0;

  async_rx_unit u_async_rx_unit (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .int_en(int_en),
    .rd_strobe(rd_strobe), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .rx_data(rx_data), .data_ready(data_ready), .ovr_err(ovr_err),
    .par_err(par_err), .frm_err(frm_err), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // driver
  task automatic send_bit(logic v);
    rxd = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] d, logic bad_par, logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (par_en) send_bit((^d) ^ par_odd ^ bad_par);
    send_bit(stop);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_evt(logic [7:0] d, logic r, logic o, logic p, logic f, string req);
    exp_t e;
    e.d = d; e.rdy = r; e.ovr = o; e.pe = p; e.fe = f; e.req = req;
    expq.push_back(e);
  endtask

  task automatic pulse_read();
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
  endtask

  task automatic write_stat(logic [2:0] m);
    stat_wdata = m; stat_wr = 1'b1; @(negedge clk);
    stat_wr = 1'b0; stat_wdata = 3'b111; @(negedge clk);
  endtask

  // monitor
  logic pr, po, pp, pf;
  always @(negedge clk) begin
    if (!rst_n) begin
      pr <= 0; po <= 0; pp <= 0; pf <= 0;
    end else begin
      if ((data_ready && !pr) || (ovr_err && !po) || (par_err && !pp) || (frm_err && !pf)) begin
        exp_t e;
        events++;
        if (expq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8 unexpected event actual=%0h expected=none", rx_data);
        end else begin
          e = expq.pop_front();
          check(e.req, "rx_data", rx_data, e.d);
          check(e.req, "flags", {data_ready, ovr_err, par_err, frm_err}, {e.rdy, e.ovr, e.pe, e.fe});
          check("R10", "irq_rx", irq_rx, e.rdy & int_en);
          check("R10", "irq_err", irq_err, (e.ovr | e.pe | e.fe) & int_en);
        end
      end
      pr <= data_ready; po <= ovr_err; pp <= par_err; pf <= frm_err;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    int ev0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset outputs", {rx_data, data_ready, ovr_err, par_err, frm_err, irq_rx, irq_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    int_en = 1'b1;

    // R2 R5: clean frame, no parity
    expect_evt(8'hA5, 1, 0, 0, 0, "R2");
    send_frame(8'hA5, 0, 1);
    check("R5", "par_err without parity", par_err, 0);
    check("R10", "irq_rx level", irq_rx, 1);
    pulse_read();
    check("R9", "ready after read", data_ready, 0);

    // R4 even parity, good
    par_en = 1'b1; par_odd = 1'b0;
    expect_evt(8'h3C, 1, 0, 0, 0, "R4");
    send_frame(8'h3C, 0, 1);
    pulse_read();

    // R4 odd parity, corrupted
    par_odd = 1'b1;
    expect_evt(8'h81, 0, 0, 1, 0, "R4");
    send_frame(8'h81, 1, 1);
    check("R10", "irq_err level", irq_err, 1);

    // R8 blocked while flag set
    ev0 = events;
    send_frame(8'h55, 0, 1);
    repeat (BIT_CLK) @(negedge clk);
    check("R8", "events while blocked", events, ev0);
    check("R8", "rx_data while blocked", rx_data, 8'h81);
    write_stat(3'b101);
    check("R9", "parity cleared", par_err, 0);
    check("R10", "irq_err after clear", irq_err, 0);

    // R6 framing error, parity off
    par_en = 1'b0;
    expect_evt(8'h0F, 0, 0, 0, 1, "R6");
    send_frame(8'h0F, 0, 0);
    repeat (BIT_CLK) @(negedge clk);
    write_stat(3'b111);
    check("R9", "write 1 leaves framing flag", frm_err, 1);
    write_stat(3'b011);
    check("R9", "framing cleared", frm_err, 0);

    // R7 overrun
    expect_evt(8'h11, 1, 0, 0, 0, "R2");
    send_frame(8'h11, 0, 1);
    expect_evt(8'h11, 1, 1, 0, 0, "R7");
    send_frame(8'h22, 0, 1);
    check("R7", "ready kept", data_ready, 1);
    write_stat(3'b110);
    check("R9", "overrun cleared", ovr_err, 0);
    pulse_read();

    // R3 noise on the line
    ev0 = events;
    rxd = 1'b0; repeat (8) @(negedge clk);
    rxd = 1'b1; repeat (3 * BIT_CLK) @(negedge clk);
    check("R3", "events after glitch", events, ev0);
    check("R3", "rx_data after glitch", rx_data, 8'h11);
    expect_evt(8'hC3, 1, 0, 0, 0, "R3");
    send_frame(8'hC3, 0, 1);
    pulse_read();

    // R10 interrupts masked
    int_en = 1'b0;
    expect_evt(8'h6E, 1, 0, 0, 0, "R10");
    send_frame(8'h6E, 0, 1);
    check("R10", "irq_rx masked", irq_rx, 0);

    repeat (10) @(negedge clk);
    check("R2", "scoreboard drained", expq.size(), 0);
    done = 1;
    summary();
  end
endmodule